// File: doc/BRIEF.md
# Selectable Math and Entropy Merge Datapath

This block is a 32-bit datapath of two stages of logic. The first stage is an eleven-way arithmetic and logic unit. Its operation comes from a 32-bit selector reduced modulo eleven. The second stage folds the result of the first stage into an accumulator word, using one of four merge functions. Every merge function keeps the entropy of the accumulator even when the incoming value carries little information. A controller that holds the register file and generates the selectors drives the operands and the two selectors on each issue. It reads back the merged word, and also the math result, which is brought out for observation.

All arithmetic is unsigned 32-bit, and any carry beyond bit 31 is dropped. An optional output register, chosen by a parameter, adds one cycle of latency. It is paired with a valid flag that follows the input valid flag.

Top module: `mix_merge_unit`

## Requirements
- R1: The math operation index is `math_sel mod 11`, computed exactly for every 32-bit selector value. Index 0 is add, 1 is low product, 2 is high product, 3 is unsigned minimum, 4 is rotate left, 5 is rotate right, 6 is AND, 7 is OR, 8 is XOR, 9 is the leading-zero sum and 10 is the population-count sum.
- R2: Add (index 0) and low product (index 1) return the lower 32 bits of the true result. High product (index 2) returns bits 63:32 of the 64-bit unsigned product of `op_a` and `op_b`.
- R3: Index 3 returns the unsigned minimum of the two operands. Indices 6, 7 and 8 return the bitwise AND, OR and XOR.
- R4: Indices 4 and 5 rotate `op_a` left or right by `op_b mod 32`. A rotate amount of 0 or 32 returns `op_a` unchanged.
- R5: Index 9 returns clz(`op_a`) + clz(`op_b`), where clz of zero is 32. Index 10 returns popcount(`op_a`) + popcount(`op_b`).
- R6: The merge mode is `merge_sel mod 4`, taken from bits 1:0. Mode 0 gives `acc_in*33 + m` modulo 2^32, where m is the math result.
- R7: Merge mode 1 gives `(acc_in XOR m)*33` modulo 2^32.
- R8: Merge modes 2 and 3 rotate `acc_in` left (mode 2) or right (mode 3) by `((merge_sel >> 16) mod 31) + 1`, then XOR with m. The rotate amount is therefore always between 1 and 31.
- R9: `math_res` carries the same math result that enters the merge, and both outputs belong to the same issue.
- R10: With the output register present, an issue accepted with `in_valid` high at a rising edge appears on `math_res` and `merged` after that edge, and `out_valid` is high for exactly that cycle. In reset, `out_valid` and both data outputs are zero.
- R11: With the output register present, a cycle with `in_valid` low leaves `math_res` and `merged` unchanged and drives `out_valid` low, whatever the operand and selector inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue qualifier for the operand and selector inputs |
| op_a | input | 32 | First math operand |
| op_b | input | 32 | Second math operand |
| math_sel | input | 32 | Math selector, reduced modulo 11 |
| acc_in | input | 32 | Accumulator word to be merged into |
| merge_sel | input | 32 | Merge selector; bits 1:0 pick the mode, bits 31:16 set the rotate amount |
| out_valid | output | 1 | Marks the cycle that carries a result |
| math_res | output | 32 | Math result of the issue |
| merged | output | 32 | Merged accumulator word |

## Verification
On every cycle, the assertions check several properties. The valid flag follows the issue by one cycle. The outputs hold while no issue is present. Each rotating operation, in the unit and in the merge, keeps the bit weight of its input. The minimum never exceeds either operand, and the count sums stay within 64. The exact arithmetic can only be shown by the bench's scenarios: product wraparound and high-half extraction, modulo-11 reduction of large selectors, clz of zero, and the rotate amount derived from the upper half of the merge selector.

// File: rtl/mix_pkg.sv
package mix_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned SHAMT_W   = $clog2(WORD_W);
   localparam int unsigned NUM_MATH  = 11;
   localparam int unsigned NUM_MERGE = 4;
   localparam int unsigned MERGE_K   = 33;
   localparam int unsigned ROT_MOD   = WORD_W - 1;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_MULLO = 4'd1,
      OP_MULHI = 4'd2,
      OP_MIN   = 4'd3,
      OP_ROTL  = 4'd4,
      OP_ROTR  = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_CLZ   = 4'd9,
      OP_POP   = 4'd10
   } math_op_e;

   typedef enum logic [1:0] {
      MG_MAC  = 2'd0,
      MG_XMUL = 2'd1,
      MG_ROL  = 2'd2,
      MG_ROR  = 2'd3
   } merge_op_e;

   function automatic word_t rot_left(input word_t x, input logic [SHAMT_W-1:0] s);
      logic [SHAMT_W:0] back;
      back = (SHAMT_W+1)'(WORD_W) - {1'b0, s};
      return (x << s) | (x >> back);
   endfunction

   function automatic word_t rot_right(input word_t x, input logic [SHAMT_W-1:0] s);
      logic [SHAMT_W:0] back;
      back = (SHAMT_W+1)'(WORD_W) - {1'b0, s};
      return (x >> s) | (x << back);
   endfunction

   function automatic logic [SHAMT_W:0] lead_zeros(input word_t x);
      logic [SHAMT_W:0] n;
      logic             seen;
      n    = '0;
      seen = 1'b0;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (x[i]) seen = 1'b1;
         if (!seen) n = n + 1'b1;
      end
      return n;
   endfunction

   function automatic logic [SHAMT_W:0] ones_count(input word_t x);
      logic [SHAMT_W:0] n;
      n = '0;
      for (int i = 0; i < WORD_W; i++) n = n + {{SHAMT_W{1'b0}}, x[i]};
      return n;
   endfunction

endpackage

// File: rtl/mix_math_alu.sv
module mix_math_alu
   import mix_pkg::*;
#(
   parameter int unsigned DATA_W = WORD_W,
   parameter int unsigned N_OPS  = NUM_MATH
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] sel,
   output logic [DATA_W-1:0] res
);

   localparam int unsigned PROD_W = 2 * DATA_W;
   localparam int unsigned CNT_W  = SHAMT_W + 2;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("mix_math_alu: DATA_W must equal the package word width");
   end
   if (N_OPS != NUM_MATH) begin : g_bad_ops
      $error("mix_math_alu: operation count must be eleven");
   end

   logic [DATA_W-1:0] sel_rem;
   logic [DATA_W-5:0] unused_rem;
   math_op_e          op;
   logic [PROD_W-1:0] prod;
   logic [CNT_W-1:0]  clz_sum;
   logic [CNT_W-1:0]  pop_sum;
   logic [SHAMT_W-1:0] shamt;
   logic [DATA_W-SHAMT_W-1:0] unused_bhi;

   assign sel_rem    = sel % DATA_W'(N_OPS);
   assign op         = math_op_e'(sel_rem[3:0]);
   assign unused_rem = sel_rem[DATA_W-1:4];
   assign prod       = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
   assign clz_sum    = {1'b0, lead_zeros(a)} + {1'b0, lead_zeros(b)};
   assign pop_sum    = {1'b0, ones_count(a)} + {1'b0, ones_count(b)};
   assign shamt      = b[SHAMT_W-1:0];
   assign unused_bhi = b[DATA_W-1:SHAMT_W];

   always_comb begin
      unique case (op)
         OP_ADD:   res = a + b;
         OP_MULLO: res = prod[DATA_W-1:0];
         OP_MULHI: res = prod[PROD_W-1:DATA_W];
         OP_MIN:   res = (a < b) ? a : b;
         OP_ROTL:  res = rot_left(a, shamt);
         OP_ROTR:  res = rot_right(a, shamt);
         OP_AND:   res = a & b;
         OP_OR:    res = a | b;
         OP_XOR:   res = a ^ b;
         OP_CLZ:   res = DATA_W'(clz_sum);
         OP_POP:   res = DATA_W'(pop_sum);
         default:  res = '0;
      endcase
   end

   always_comb begin
      if (op == OP_MIN) begin
         a_r3_min_bound: assert (res <= a && res <= b)
            else $error("R3 minimum exceeds an operand");
      end
      if (op == OP_ROTL || op == OP_ROTR) begin
         a_r4_rot_weight: assert ($countones(res) == $countones(a))
            else $error("R4 rotate changed bit weight");
      end
      if (op == OP_CLZ || op == OP_POP) begin
         a_r5_count_range: assert (res <= DATA_W'(2 * DATA_W))
            else $error("R5 count sum out of range");
      end
   end

endmodule

// File: rtl/mix_merge.sv
module mix_merge
   import mix_pkg::*;
#(
   parameter int unsigned DATA_W = WORD_W,
   parameter int unsigned MULT   = MERGE_K
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] sel,
   output logic [DATA_W-1:0] res
);

   localparam int unsigned HALF_W = DATA_W / 2;

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("mix_merge: DATA_W must equal the package word width");
   end
   if (MULT % 2 == 0) begin : g_bad_mult
      $error("mix_merge: multiplier must be odd to keep entropy");
   end

   merge_op_e          mode;
   logic [HALF_W-1:0]  hi_rem;
   logic [SHAMT_W-1:0] rot_amt;
   logic [HALF_W-SHAMT_W-1:0] unused_hi_rem;
   logic [HALF_W-3:0]  unused_sel_mid;
   logic [DATA_W-1:0]  mixed;

   assign mode           = merge_op_e'(sel[1:0]);
   assign unused_sel_mid = sel[HALF_W-1:2];
   assign hi_rem         = sel[DATA_W-1:HALF_W] % HALF_W'(ROT_MOD);
   assign unused_hi_rem  = hi_rem[HALF_W-1:SHAMT_W];
   assign rot_amt        = hi_rem[SHAMT_W-1:0] + 1'b1;
   assign mixed          = acc ^ val;

   always_comb begin
      unique case (mode)
         MG_MAC:  res = acc * DATA_W'(MULT) + val;
         MG_XMUL: res = mixed * DATA_W'(MULT);
         MG_ROL:  res = rot_left(acc, rot_amt) ^ val;
         MG_ROR:  res = rot_right(acc, rot_amt) ^ val;
         default: res = '0;
      endcase
   end

   always_comb begin
      if (mode == MG_ROL || mode == MG_ROR) begin
         a_r8_rot_weight: assert ($countones(res ^ val) == $countones(acc))
            else $error("R8 merge rotate changed bit weight");
      end
   end

endmodule

// File: rtl/mix_merge_unit.sv
module mix_merge_unit
   import mix_pkg::*;
#(
   parameter int unsigned DATA_W  = WORD_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] math_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] merge_sel,
   output logic              out_valid,
   output logic [DATA_W-1:0] math_res,
   output logic [DATA_W-1:0] merged
);

   logic [DATA_W-1:0] alu_q;
   logic [DATA_W-1:0] mrg_q;

   mix_math_alu #(.DATA_W(DATA_W), .N_OPS(NUM_MATH)) u_alu (
      .a   (op_a),
      .b   (op_b),
      .sel (math_sel),
      .res (alu_q)
   );

   mix_merge #(.DATA_W(DATA_W), .MULT(MERGE_K)) u_mrg (
      .acc (acc_in),
      .val (alu_q),
      .sel (merge_sel),
      .res (mrg_q)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            math_res  <= '0;
            merged    <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               math_res <= alu_q;
               merged   <= mrg_q;
            end
         end
      end

      a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid)
         else $error("R10 result flag missing after issue");

      a_r11_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid)
         else $error("R11 result flag without issue");

      a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(merged) && $stable(math_res)))
         else $error("R11 outputs moved without issue");
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign math_res   = alu_q;
      assign merged     = mrg_q;
   end

endmodule

// File: tb/test_mix_merge_unit.sv
module test_mix_merge_unit;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, math_sel = '0, acc_in = '0, merge_sel = '0;
   logic         out_valid;
   logic [W-1:0] math_res, merged;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mix_merge_unit #(.DATA_W(W), .REG_OUT(1'b1)) i_mix_merge_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .math_sel(math_sel),
      .acc_in(acc_in), .merge_sel(merge_sel),
      .out_valid(out_valid), .math_res(math_res), .merged(merged)
   );

   typedef struct packed {
      logic [31:0] a, b, ms, acc, rs, exp_m, exp_g;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{32'hFFFFFFFF, 32'h2,        32'd0,  32'h1,        32'h0,        32'h1,        32'h22},
      '{32'h00010000, 32'h00010000, 32'd1,  32'h3,        32'h1,        32'h0,        32'h63},
      '{32'h00010000, 32'h00010000, 32'd2,  32'h0,        32'h4,        32'h1,        32'h1},
      '{32'h5,        32'h7,        32'd3,  32'h80000001, 32'h2,        32'h5,        32'h6},
      '{32'h80000001, 32'd33,       32'd4,  32'h3,        32'h3,        32'h3,        32'h80000002},
      '{32'h12345678, 32'd32,       32'd5,  32'h2,        32'h001E0002, 32'h12345678, 32'h12345679},
      '{32'hF0F0F0F0, 32'hFF00FF00, 32'd6,  32'h4,        32'h001F0003, 32'hF000F000, 32'hF000F002},
      '{32'h0F,       32'hF0,       32'd7,  32'h1,        32'h00200002, 32'hFF,       32'hFB},
      '{32'hFF,       32'h0F,       32'd8,  32'h0F,       32'h1,        32'hF0,       32'h20DF},
      '{32'h0,        32'h1,        32'd9,  32'h2,        32'h0,        32'h3F,       32'h81},
      '{32'hFFFFFFFF, 32'h3,        32'd10, 32'h0,        32'h0,        32'h22,       32'h22},
      '{32'h9,        32'h4,        32'hFFFFFFFF, 32'hC,  32'hFFFFFFFF, 32'h4,        32'h7},
      '{32'h1,        32'h1,        32'd11, 32'h0,        32'h0,        32'h2,        32'h2},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1,  32'hFFFFFFFF, 32'h0,        32'h1,        32'hFFFFFFE0},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'd2,  32'hFFFFFFFF, 32'h0,        32'hFFFFFFFE, 32'hFFFFFFDD},
      '{32'hA5A5A5A5, 32'h0,        32'd4,  32'h0,        32'h1,        32'hA5A5A5A5, 32'h5A5A5A45},
      '{32'h80000000, 32'h7FFFFFFF, 32'd3,  32'h0,        32'h0,        32'h7FFFFFFF, 32'h7FFFFFFF}
   };

   function automatic logic [31:0] m_rotl(logic [31:0] x, int s);
      logic [63:0] t;
      t = {x, x} << (s % 32);
      return t[63:32];
   endfunction

   function automatic logic [31:0] m_rotr(logic [31:0] x, int s);
      logic [63:0] t;
      t = {x, x} >> (s % 32);
      return t[31:0];
   endfunction

   function automatic int m_clz(logic [31:0] x);
      int n = 0;
      while (n < 32 && x[31-n] == 1'b0) n++;
      return n;
   endfunction

   function automatic logic [31:0] m_math(logic [31:0] a, logic [31:0] b, logic [31:0] s);
      logic [63:0] p;
      longint unsigned idx;
      idx = longint'(s) % 11;
      p = 64'(a) * 64'(b);
      case (idx)
         0: return a + b;
         1: return p[31:0];
         2: return p[63:32];
         3: return (a < b) ? a : b;
         4: return m_rotl(a, int'(b[4:0]));
         5: return m_rotr(a, int'(b[4:0]));
         6: return a & b;
         7: return a | b;
         8: return a ^ b;
         9: return 32'(m_clz(a) + m_clz(b));
         default: return 32'($countones(a) + $countones(b));
      endcase
   endfunction

   function automatic logic [31:0] m_merge(logic [31:0] c, logic [31:0] v, logic [31:0] s);
      int amt;
      amt = (int'(s[31:16]) % 31) + 1;
      case (s % 4)
         0: return c * 32'd33 + v;
         1: return (c ^ v) * 32'd33;
         2: return m_rotl(c, amt) ^ v;
         default: return m_rotr(c, amt) ^ v;
      endcase
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(logic [31:0] a, logic [31:0] b, logic [31:0] ms,
                        logic [31:0] c, logic [31:0] rs);
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; math_sel = ms; acc_in = c; merge_sel = rs;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      logic [31:0] ra, rb, rms, rc, rrs;
      logic [31:0] held_g, held_m;

      // R10: reset state, with an issue presented during reset
      in_valid = 1'b1; op_a = 32'h5; op_b = 32'h6; acc_in = 32'h7;
      repeat (3) @(negedge clk);
      check("R10", "reset out_valid", {31'b0, out_valid}, 32'h0);
      check("R10", "reset merged", merged, 32'h0);
      check("R10", "reset math_res", math_res, 32'h0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].a, VECS[i].b, VECS[i].ms, VECS[i].acc, VECS[i].rs);
         check("R1-R5", $sformatf("vec%0d math_res", i), math_res, VECS[i].exp_m);
         check("R6-R8", $sformatf("vec%0d merged", i), merged, VECS[i].exp_g);
         check("R10", $sformatf("vec%0d out_valid", i), {31'b0, out_valid}, 32'h1);
      end

      // R11: inputs change with in_valid low; outputs hold, flag low
      held_g = merged; held_m = math_res;
      op_a = 32'hDEADBEEF; op_b = 32'h1234; math_sel = 32'd1; acc_in = 32'h55; merge_sel = 32'h2;
      @(negedge clk);
      check("R11", "idle out_valid", {31'b0, out_valid}, 32'h0);
      check("R11", "idle merged hold", merged, held_g);
      check("R11", "idle math_res hold", math_res, held_m);
      @(negedge clk);
      check("R11", "idle second cycle merged", merged, held_g);

      // R10: back-to-back issues each land one cycle later
      @(negedge clk);
      in_valid = 1'b1; op_a = 32'd10; op_b = 32'd20; math_sel = 32'd0; acc_in = 32'd0; merge_sel = 32'd0;
      @(negedge clk);
      check("R10", "b2b first", merged, 32'd30);
      op_a = 32'd3; op_b = 32'd4; math_sel = 32'd1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10", "b2b second", merged, 32'd12);
      check("R9", "b2b math_res", math_res, 32'd12);

      // R8 edge: upper half gives remainder 30 and 0 (amounts 31 and 1)
      issue(32'd0, 32'd0, 32'd0, 32'h00000001, 32'h001E0003);
      check("R8", "rotr by 31", merged, 32'h00000002);
      issue(32'd0, 32'd0, 32'd0, 32'h00000001, 32'h003E0002);
      check("R8", "rotl by 1 via 62 mod 31", merged, 32'h00000002);

      // Sweep against the bench model: R1 R2 R3 R4 R5 R6 R7 R8 R9
      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 300; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; ra  = lfsr * 32'h9E3779B9;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rb  = lfsr ^ (ra >> 7);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rms = lfsr * 32'h85EBCA6B;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rc  = lfsr + ra;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; rrs = lfsr * 32'hC2B2AE35;
         if (k % 5 == 0) rb = rb & 32'h3F;
         issue(ra, rb, rms, rc, rrs);
         check("R1", $sformatf("sweep%0d math_res", k), math_res, m_math(ra, rb, rms));
         check("R9", $sformatf("sweep%0d merged", k), merged,
               m_merge(rc, m_math(ra, rb, rms), rrs));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule